// File: doc/BRIEF.md
# Pointer Adder with Mode-Dependent Flags

This block performs the 16-bit address arithmetic of a small 8-bit processor core. It has two modes. In the register-pair mode it adds a 16-bit source pair into the HL accumulator. In the stack-offset mode it adds a signed 8-bit offset to the stack pointer. The caller supplies the operands: the current HL or SP value, the source pair value, and the offset byte. The block returns the 16-bit result and the four status flags. Each mode has its own rule for those flags.

Operands and the mode are sampled on a rising clock edge. The result and the flags appear on the outputs one cycle later and hold until the next edge. Register storage, operand fetch and write-back belong to the surrounding core. To add HL to itself, the caller drives the same value on both operand ports.

Top module: `ptr_adder_unit`

## Requirements
- R1: With `mode_i` = 0 (register-pair mode), `sum_o` equals `base_i + src_i` modulo 2^16, one clock after the operands are sampled.
- R2: In register-pair mode, `z_o` equals the `z_in_i` value that was sampled with the operands.
- R3: `n_o` is 0 after every operation in either mode.
- R4: In register-pair mode, `h_o` is the carry out of bit 11 of `base_i + src_i`.
- R5: In register-pair mode, `c_o` is the carry out of bit 15 of `base_i + src_i`.
- R6: With `mode_i` = 1 (stack-offset mode), `sum_o` equals `base_i` plus `imm_i` sign-extended from bit 7, modulo 2^16.
- R7: In stack-offset mode, `z_o` is 0 whatever `z_in_i` holds.
- R8: In stack-offset mode, `h_o` is the carry out of bit 3 of the unsigned sum `base_i[7:0] + imm_i`.
- R9: In stack-offset mode, `c_o` is the carry out of bit 7 of the unsigned sum `base_i[7:0] + imm_i`.
- R10: In stack-offset mode, `src_i` and `z_in_i` do not affect any output. In register-pair mode, `imm_i` does not affect any output.
- R11: While `rst_n` is low, `sum_o`, `z_o`, `n_o`, `h_o` and `c_o` are all 0.
- R12: When both operands carry the same value (HL added to itself), `sum_o` is twice that value modulo 2^16, and the flags follow R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 = register-pair add, 1 = stack-offset add |
| base_i | input | 16 | Current HL (pair mode) or SP (offset mode) |
| src_i | input | 16 | Source pair value (pair mode only) |
| imm_i | input | 8 | Signed offset byte (offset mode only) |
| z_in_i | input | 1 | Current zero flag, passed through in pair mode |
| sum_o | output | 16 | Registered 16-bit result |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Subtract flag |
| h_o | output | 1 | Half-carry flag |
| c_o | output | 1 | Carry flag |

## Verification
Pair-mode operands are chosen to produce carries at different points. One pattern carries only out of bit 11, one only out of bit 15, one does both and wraps to zero, and one produces no carry at all. These show whether the half-carry tap and the carry tap sit at the right bit positions. Offset-mode patterns use positive offsets, negative offsets and the two extremes, so that a missing sign extension or a wrong wrap shows up in the upper byte. In those patterns the low-byte carries do not match the 16-bit carries, which shows whether the flags are taken from the low byte. The ignored inputs are toggled between otherwise identical operations, an equal-operand case doubles a value, and a batch of random operands covers both modes.

// File: rtl/ptr_add_pkg.sv
package ptr_add_pkg;

    typedef enum logic {
        MODE_PAIR  = 1'b0,
        MODE_SPOFS = 1'b1
    } add_mode_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/pa_operand_sel.sv
module pa_operand_sel
    import ptr_add_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  add_mode_e          mode,
    input  logic [W-1:0]       src,
    input  logic [IMM_W-1:0]   imm,
    output logic [W-1:0]       addend
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        addend  = (mode == MODE_SPOFS) ? imm_ext : src;
    end
endmodule

// File: rtl/pa_carry_adder.sv
module pa_carry_adder #(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         co_nib_lo,
    output logic         co_byte_lo,
    output logic         co_nib_hi,
    output logic         co_top
);
    localparam int K_NIB_LO  = IMM_W / 2 - 1;
    localparam int K_BYTE_LO = IMM_W - 1;
    localparam int K_NIB_HI  = W - 5;

    logic [W:0] full;

    always_comb begin
        full       = {1'b0, a} + {1'b0, b};
        sum        = full[W-1:0];
        co_nib_lo  = a[K_NIB_LO+1]  ^ b[K_NIB_LO+1]  ^ full[K_NIB_LO+1];
        co_byte_lo = a[K_BYTE_LO+1] ^ b[K_BYTE_LO+1] ^ full[K_BYTE_LO+1];
        co_nib_hi  = a[K_NIB_HI+1]  ^ b[K_NIB_HI+1]  ^ full[K_NIB_HI+1];
        co_top     = full[W];
    end
endmodule

// File: rtl/pa_flag_gen.sv
module pa_flag_gen
    import ptr_add_pkg::*;
(
    input  add_mode_e mode,
    input  logic      z_in,
    input  logic      co_nib_lo,
    input  logic      co_byte_lo,
    input  logic      co_nib_hi,
    input  logic      co_top,
    output flags_t    flags
);
    always_comb begin
        flags.n = 1'b0;
        if (mode == MODE_SPOFS) begin
            flags.z = 1'b0;
            flags.h = co_nib_lo;
            flags.c = co_byte_lo;
        end else begin
            flags.z = z_in;
            flags.h = co_nib_hi;
            flags.c = co_top;
        end
    end
endmodule

// File: rtl/ptr_adder_unit.sv
module ptr_adder_unit
    import ptr_add_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic [W-1:0]     base_i,
    input  logic [W-1:0]     src_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             z_in_i,
    output logic [W-1:0]     sum_o,
    output logic             z_o,
    output logic             n_o,
    output logic             h_o,
    output logic             c_o
);
    typedef struct packed {
        logic [W-1:0] sum;
        flags_t       fl;
    } res_t;

    add_mode_e    mode_w;
    logic [W-1:0] addend_w;
    logic [W-1:0] sum_w;
    logic         co_nib_lo_w, co_byte_lo_w, co_nib_hi_w, co_top_w;
    flags_t       flags_w;
    res_t         res_d, res_q;

    assign mode_w = add_mode_e'(mode_i);

    pa_operand_sel #(.W(W), .IMM_W(IMM_W)) u_sel (
        .mode   (mode_w),
        .src    (src_i),
        .imm    (imm_i),
        .addend (addend_w)
    );

    pa_carry_adder #(.W(W), .IMM_W(IMM_W)) u_add (
        .a          (base_i),
        .b          (addend_w),
        .sum        (sum_w),
        .co_nib_lo  (co_nib_lo_w),
        .co_byte_lo (co_byte_lo_w),
        .co_nib_hi  (co_nib_hi_w),
        .co_top     (co_top_w)
    );

    pa_flag_gen u_flags (
        .mode       (mode_w),
        .z_in       (z_in_i),
        .co_nib_lo  (co_nib_lo_w),
        .co_byte_lo (co_byte_lo_w),
        .co_nib_hi  (co_nib_hi_w),
        .co_top     (co_top_w),
        .flags      (flags_w)
    );

    always_comb begin
        res_d.sum = sum_w;
        res_d.fl  = flags_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o = res_q.sum;
    assign z_o   = res_q.fl.z;
    assign n_o   = res_q.fl.n;
    assign h_o   = res_q.fl.h;
    assign c_o   = res_q.fl.c;

    a_r1_pair_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b0) |=> (sum_o == $past(base_i + src_i)));

    a_r2_z_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b0) |=> (z_o == $past(z_in_i)));

    a_r3_n_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> !n_o);

    a_r6_sp_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b1) |=> (sum_o == $past(base_i + W'($signed(imm_i)))));

    a_r7_z_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b1) |=> !z_o);

    a_r9_low_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b1) |=>
            (c_o == $past((({1'b0, base_i[IMM_W-1:0]} + {1'b0, imm_i}) >> IMM_W) != 0)));
endmodule

// File: tb/ptr_adder_unit_tb.sv
module ptr_adder_unit_tb;
    localparam int W = 16;

    typedef struct {
        logic [15:0] sum;
        logic        z, n, h, c;
        logic        mode;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic [15:0] base_i = '0, src_i = '0;
    logic [7:0]  imm_i = '0;
    logic        z_in_i = 1'b0;
    logic [15:0] sum_o;
    logic        z_o, n_o, h_o, c_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    ptr_adder_unit #(.W(W), .IMM_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .base_i(base_i),
        .src_i(src_i), .imm_i(imm_i), .z_in_i(z_in_i),
        .sum_o(sum_o), .z_o(z_o), .n_o(n_o), .h_o(h_o), .c_o(c_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic [15:0] b, input logic [15:0] s,
                         input logic [7:0] im, input logic zi, input string tag);
        exp_t e;
        logic [16:0] full;
        logic [15:0] ext;
        @(negedge clk);
        mode_i = m; base_i = b; src_i = s; imm_i = im; z_in_i = zi;
        e.mode = m; e.tag = tag; e.n = 1'b0;
        if (!m) begin
            full  = {1'b0, b} + {1'b0, s};
            e.sum = full[15:0];
            e.z   = zi;
            e.h   = ({1'b0, b[11:0]} + {1'b0, s[11:0]}) > 13'h0FFF;
            e.c   = full[16];
        end else begin
            ext   = {{8{im[7]}}, im};
            e.sum = b + ext;
            e.z   = 1'b0;
            e.h   = ({1'b0, b[3:0]} + {1'b0, im[3:0]}) > 5'h0F;
            e.c   = ({1'b0, b[7:0]} + {1'b0, im}) > 9'h0FF;
        end
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk({e.tag, e.mode ? " R6 sum" : " R1 sum"}, sum_o, e.sum);
                chk({e.tag, e.mode ? " R7 z" : " R2 z"}, 16'(z_o), 16'(e.z));
                chk({e.tag, " R3 n"}, 16'(n_o), 16'(e.n));
                chk({e.tag, e.mode ? " R8 h" : " R4 h"}, 16'(h_o), 16'(e.h));
                chk({e.tag, e.mode ? " R9 c" : " R5 c"}, 16'(c_o), 16'(e.c));
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        // R11: outputs cleared under reset, even with live operands
        base_i = 16'hFFFF; src_i = 16'h0001; z_in_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset sum", sum_o, 16'h0000);
        chk("R11 reset flags", {12'h0, z_o, n_o, h_o, c_o}, 16'h0000);
        rst_n = 1'b1;

        // Pair mode: carry taps R4, R5
        drive(1'b0, 16'h0FFF, 16'h0001, 8'h00, 1'b0, "R4 bit11 only");
        drive(1'b0, 16'h8000, 16'h8000, 8'h00, 1'b1, "R5 bit15 only");
        drive(1'b0, 16'hFFFF, 16'h0001, 8'h00, 1'b1, "R1 wrap");
        drive(1'b0, 16'h1234, 16'h1111, 8'h00, 1'b0, "R1 plain");
        // R12: HL + HL
        drive(1'b0, 16'h8800, 16'h8800, 8'h00, 1'b0, "R12 double");
        drive(1'b0, 16'h4321, 16'h4321, 8'h00, 1'b1, "R12 double small");
        // R10: imm ignored in pair mode
        drive(1'b0, 16'h1234, 16'h1111, 8'hFF, 1'b0, "R10 imm ignored");

        // Offset mode R6..R9
        drive(1'b1, 16'hFFF8, 16'h0000, 8'h08, 1'b0, "R6 wrap up");
        drive(1'b1, 16'h0005, 16'h0000, 8'hFE, 1'b0, "R6 negative");
        drive(1'b1, 16'h0000, 16'h0000, 8'hFF, 1'b0, "R6 minus one");
        drive(1'b1, 16'h7FFF, 16'h0000, 8'h7F, 1'b0, "R9 max pos");
        drive(1'b1, 16'h1000, 16'h0000, 8'h80, 1'b0, "R6 max neg");
        // R10: src and z_in ignored in offset mode (R7)
        drive(1'b1, 16'h0005, 16'hABCD, 8'hFE, 1'b1, "R10 src z ignored");
        drive(1'b1, 16'h00F0, 16'hFFFF, 8'h10, 1'b1, "R7 z forced");

        for (int i = 0; i < 60; i++) begin
            drive(1'(i % 2), 16'($urandom), 16'($urandom), 8'($urandom),
                  1'($urandom), "random");
        end

        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule